// File: doc/BRIEF.md
# External Memory Bus Controller

This block sits between an internal requester and an asynchronous external memory bus with a 26-bit address and a 16-bit data path. A request names a byte, halfword or word, its address, a direction and, for writes, the data. The block runs one or more bus accesses. It drives the address, the six active-low chip enables, the active-low output and write enables, and a byte-width indicator. It then returns a single done pulse, with assembled read data when the request was a read.

Every access has a setup cycle, in which address and chip enable are valid, and a strobe cycle. An external wait input can stretch the strobe cycle. The wait input is sampled on the falling clock edge inside the strobe cycle. Each active sample adds one more strobe cycle.

The top three address bits pick a region. Regions 0 to 5 drive chip enables 0 to 5. Regions 6 and 7 run the bus cycle with no chip enable. Region 0 holds the boot device, and its port width comes from a strap captured when reset is released. The other regions take their width from a fixed mask. A request wider than its port is split into little-endian accesses.

Top module: `ext_bus_ctrl`

## Requirements
- R1: While rst_ni is low, ext_oe_no, ext_we_no and every ext_ce_no bit are high, ext_data_oe_o and done_o are low, and ready_o is high.
- R2: A read access drives ext_ce_no and ext_addr_o for one setup cycle with both enables high. It then holds ext_oe_no low for the strobe cycle, while ext_we_no stays high and ext_data_oe_o stays low.
- R3: A write access has the same setup cycle as a read. In the strobe cycle it holds ext_we_no low while ext_oe_no stays high. ext_data_oe_o is high and ext_data_o carries that access's data.
- R4: ext_oe_no and ext_we_no are never low together. Both are high in every setup cycle and in the cycle after each access ends.
- R5: ext_wait_i is sampled on the falling clock edge inside each strobe cycle. Each high sample adds one strobe cycle, and a high level during a setup cycle has no effect. A request that needs N accesses with W wait cycles in total lasts 2N+W cycles from the accepting edge to the done edge.
- R6: ext_wide_o is low during every access of a byte request (size_i=0). It is high during halfword (size_i=1) and word (size_i=2) requests, whatever the port width.
- R7: boot_wide_i is captured on the rising edge of rst_ni. Low makes region 0 an 8-bit port and high makes it a 16-bit port. Later changes of boot_wide_i have no effect until the next reset.
- R8: The region is ext_addr_o[25:23]. Regions 0 to 5 drive only ext_ce_no[region] low during the access. Regions 6 and 7 drive no chip enable.
- R9: A request on an 8-bit port takes one access per byte, at addresses base, base+1, and so on. A request on a 16-bit port takes one access per halfword, at base, base+2. Regions 2 and 3 are 8-bit ports. Regions 1, 4, 5, 6 and 7 are 16-bit ports.
- R10: done_o pulses for exactly one cycle per request. In that cycle rdata_o holds the read bytes in little-endian order with the unused upper bytes zero. ready_o is high only when no request is in progress.
- R11: On an 8-bit port, data uses ext_data_o[7:0] and ext_data_i[7:0], and ext_data_o[15:8] is zero. A byte write on a 16-bit port drives the byte on both lanes. A byte read on a 16-bit port takes ext_data_i[15:8] when the address is odd and ext_data_i[7:0] when it is even.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| req_i | input | 1 | Request, taken when ready_o is high |
| we_i | input | 1 | 1 = write, 0 = read |
| size_i | input | 2 | 0 byte, 1 halfword, 2 word |
| addr_i | input | 26 | Request byte address |
| wdata_i | input | 32 | Write data, little-endian |
| ready_o | output | 1 | Idle, next request accepted |
| done_o | output | 1 | One-cycle completion pulse |
| rdata_o | output | 32 | Assembled read data |
| boot_wide_i | input | 1 | Boot port width strap |
| ext_addr_o | output | 26 | External address |
| ext_data_o | output | 16 | External write data |
| ext_data_i | input | 16 | External read data |
| ext_data_oe_o | output | 1 | Write data drive enable |
| ext_oe_no | output | 1 | Output enable, active low |
| ext_we_no | output | 1 | Write enable, active low |
| ext_ce_no | output | 6 | Chip enables, active low |
| ext_wide_o | output | 1 | Low for byte requests |
| ext_wait_i | input | 1 | Wait request, active high |

## Verification
On every cycle, the assertions check that the enables are mutually exclusive and that at most one chip enable is low. They also check that the address holds steady into each strobe, that a high wait sample keeps the strobe, that the strobe is released after the last strobe cycle, and that the boot strap stays fixed while out of reset. The split counts, beat addresses, lane placement, read assembly, total cycle count with waits, and strap capture at reset release only show in the bench's scenarios. The bench sweeps every region, size and direction under both strap values, with wait and setup-noise patterns.

// File: rtl/ebc_pkg.sv
package ebc_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_SETUP, ST_STROBE} bus_state_e;
  localparam logic [1:0] SZ_BYTE = 2'd0;
  localparam logic [1:0] SZ_HALF = 2'd1;
endpackage

// File: rtl/ebc_strap_capture.sv
module ebc_strap_capture (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic strap_i,
  output logic boot_wide_o
);
  logic wide_q;
  logic armed_q;

  // Strap taken on reset release only
  always_ff @(posedge rst_ni) wide_q <= strap_i;

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) armed_q <= 1'b0;
    else         armed_q <= 1'b1;

  assign boot_wide_o = wide_q;

  assert_strap_held_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    armed_q |-> $stable(wide_q));
endmodule

// File: rtl/ebc_wait_sampler.sv
module ebc_wait_sampler (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic wait_i,
  output logic wait_o
);
  logic wait_q;
  // Falling-edge sample: lands mid-cycle, ahead of the deciding rising edge
  always_ff @(negedge clk_i or negedge rst_ni)
    if (!rst_ni) wait_q <= 1'b0;
    else         wait_q <= wait_i;
  assign wait_o = wait_q;
endmodule

// File: rtl/ebc_port_map.sv
module ebc_port_map #(
  parameter int              REGION_W    = 3,
  parameter int              NUM_CE      = 6,
  parameter logic [NUM_CE-1:0] NARROW_MASK = 6'b001100
) (
  input  logic [REGION_W-1:0] region_i,
  input  logic                boot_wide_i,
  output logic [NUM_CE-1:0]   ce_sel_o,
  output logic                narrow_o
);
  logic [NUM_CE-1:0] narrow_bits;

  for (genvar g = 0; g < NUM_CE; g++) begin : g_region
    assign ce_sel_o[g] = (region_i == REGION_W'(g));
    if (g == 0) begin : g_boot
      assign narrow_bits[g] = ~boot_wide_i;
    end else begin : g_fixed
      assign narrow_bits[g] = NARROW_MASK[g];
    end
  end

  assign narrow_o = |(ce_sel_o & narrow_bits);
endmodule

// File: rtl/ext_bus_ctrl.sv
module ext_bus_ctrl
  import ebc_pkg::*;
#(
  parameter int                ADDR_W      = 26,
  parameter int                DATA_W      = 16,
  parameter int                REQ_W       = 32,
  parameter int                NUM_CE      = 6,
  parameter int                REGION_W    = 3,
  parameter logic [NUM_CE-1:0] NARROW_MASK = 6'b001100
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [1:0]        size_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [REQ_W-1:0]  wdata_i,
  output logic              ready_o,
  output logic              done_o,
  output logic [REQ_W-1:0]  rdata_o,
  input  logic              boot_wide_i,
  output logic [ADDR_W-1:0] ext_addr_o,
  output logic [DATA_W-1:0] ext_data_o,
  input  logic [DATA_W-1:0] ext_data_i,
  output logic              ext_data_oe_o,
  output logic              ext_oe_no,
  output logic              ext_we_no,
  output logic [NUM_CE-1:0] ext_ce_no,
  output logic              ext_wide_o,
  input  logic              ext_wait_i
);
  localparam int LANE_W = 8;
  localparam int BEAT_W = $clog2(REQ_W / LANE_W);

  bus_state_e        state_q;
  logic              we_q, narrow_q, done_q;
  logic [1:0]        size_q;
  logic [ADDR_W-1:0] base_q;
  logic [REQ_W-1:0]  wdata_q, rdata_q;
  logic [BEAT_W-1:0] beat_q, last_q, req_last;

  logic              boot_wide, wait_s, map_narrow;
  logic [NUM_CE-1:0] ce_sel;
  logic [ADDR_W-1:0] map_addr, beat_addr;
  logic [DATA_W-1:0] wr_beat;
  logic              active, strobe, beat_end;

  ebc_strap_capture u_strap (
    .clk_i(clk_i), .rst_ni(rst_ni), .strap_i(boot_wide_i), .boot_wide_o(boot_wide));

  ebc_wait_sampler u_wait (
    .clk_i(clk_i), .rst_ni(rst_ni), .wait_i(ext_wait_i), .wait_o(wait_s));

  assign map_addr = (state_q == ST_IDLE) ? addr_i : base_q;

  ebc_port_map #(.REGION_W(REGION_W), .NUM_CE(NUM_CE), .NARROW_MASK(NARROW_MASK)) u_map (
    .region_i(map_addr[ADDR_W-1 -: REGION_W]), .boot_wide_i(boot_wide),
    .ce_sel_o(ce_sel), .narrow_o(map_narrow));

  always_comb begin
    unique case (size_i)
      SZ_BYTE: req_last = '0;
      SZ_HALF: req_last = map_narrow ? BEAT_W'(1) : '0;
      default: req_last = map_narrow ? BEAT_W'(3) : BEAT_W'(1);
    endcase
  end

  assign active    = (state_q != ST_IDLE);
  assign strobe    = (state_q == ST_STROBE);
  assign beat_end  = strobe && !wait_s;
  assign beat_addr = base_q + (narrow_q ? ADDR_W'(beat_q) : ADDR_W'({beat_q, 1'b0}));
  assign wr_beat   = DATA_W'(wdata_q >> (int'(beat_q) * (narrow_q ? LANE_W : DATA_W)));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_IDLE;
      we_q     <= 1'b0;
      narrow_q <= 1'b0;
      size_q   <= SZ_BYTE;
      base_q   <= '0;
      wdata_q  <= '0;
      rdata_q  <= '0;
      beat_q   <= '0;
      last_q   <= '0;
      done_q   <= 1'b0;
    end else begin
      done_q <= beat_end && (beat_q == last_q);
      unique case (state_q)
        ST_IDLE: if (req_i) begin
          state_q  <= ST_SETUP;
          we_q     <= we_i;
          size_q   <= size_i;
          base_q   <= addr_i;
          wdata_q  <= wdata_i;
          narrow_q <= map_narrow;
          last_q   <= req_last;
          beat_q   <= '0;
          rdata_q  <= '0;
        end
        ST_SETUP: state_q <= ST_STROBE;
        default: if (!wait_s) begin
          if (!we_q) begin
            if (narrow_q)
              rdata_q[int'(beat_q)*LANE_W +: LANE_W] <= ext_data_i[LANE_W-1:0];
            else if (size_q == SZ_BYTE)
              rdata_q[LANE_W-1:0] <= beat_addr[0] ? ext_data_i[DATA_W-1 -: LANE_W]
                                                  : ext_data_i[LANE_W-1:0];
            else
              rdata_q[int'(beat_q)*DATA_W +: DATA_W] <= ext_data_i;
          end
          if (beat_q == last_q) state_q <= ST_IDLE;
          else begin
            state_q <= ST_SETUP;
            beat_q  <= beat_q + 1'b1;
          end
        end
      endcase
    end
  end

  assign ready_o       = !active;
  assign done_o        = done_q;
  assign rdata_o       = rdata_q;
  assign ext_addr_o    = active ? beat_addr : '0;
  assign ext_ce_no     = active ? ~ce_sel : '1;
  assign ext_oe_no     = !(strobe && !we_q);
  assign ext_we_no     = !(strobe && we_q);
  assign ext_data_oe_o = active && we_q;
  assign ext_wide_o    = active ? (size_q != SZ_BYTE) : 1'b1;

  always_comb begin
    if (narrow_q)                 ext_data_o = {{(DATA_W-LANE_W){1'b0}}, wr_beat[LANE_W-1:0]};
    else if (size_q == SZ_BYTE)   ext_data_o = {2{wdata_q[LANE_W-1:0]}};
    else                          ext_data_o = wr_beat;
  end

  assert_strobe_excl_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(!ext_oe_no && !ext_we_no));
  assert_ce_onehot_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(~ext_ce_no));
  assert_addr_setup_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($fell(ext_oe_no) || $fell(ext_we_no)) |-> $stable(ext_addr_o));
  assert_wait_holds_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (strobe && wait_s) |=> (!ext_oe_no || !ext_we_no));
  assert_strobe_release_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    beat_end |=> (ext_oe_no && ext_we_no));
  assert_done_after_strobe_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> $past(strobe));
endmodule

// File: tb/ext_bus_ctrl_test.sv
module ext_bus_ctrl_test;
  logic        clk_i = 0, rst_ni = 0, req_i = 0, we_i = 0, boot_wide_i = 0, ext_wait_i = 0;
  logic [1:0]  size_i = 0;
  logic [25:0] addr_i = 0;
  logic [31:0] wdata_i = 0;
  logic        ready_o, done_o, ext_data_oe_o, ext_oe_no, ext_we_no, ext_wide_o;
  logic [31:0] rdata_o;
  logic [25:0] ext_addr_o;
  logic [15:0] ext_data_o, ext_data_i;
  logic [5:0]  ext_ce_no;

  int n_chk = 0, n_fail = 0;
  bit finished = 0, tb_boot = 0, cur_narrow = 0;

  always #2 clk_i = ~clk_i;

  ext_bus_ctrl uut (.*);

  function automatic logic [7:0] mb(input logic [25:0] a);
    return a[7:0] ^ 8'h5A ^ {5'b0, a[25:23]};
  endfunction

  always_comb
    ext_data_i = cur_narrow ? {8'hEE, mb(ext_addr_o)}
                            : {mb(ext_addr_o | 26'd1), mb(ext_addr_o & ~26'd1)};

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic do_reset(input bit strap);
    rst_ni = 0; boot_wide_i = strap; req_i = 0; ext_wait_i = 0;
    repeat (3) @(posedge clk_i);
    #1;
    chk(ext_oe_no && ext_we_no && ext_ce_no == 6'h3F && !done_o && !ext_data_oe_o && ready_o,
        "R1 reset outputs", {ext_oe_no, ext_we_no, ext_ce_no, done_o, ext_data_oe_o, ready_o},
        {2'b11, 6'h3F, 3'b001});
    rst_ni = 1; tb_boot = strap;
    @(posedge clk_i); #1;
  endtask

  task automatic run_txn(input int region, input int sz, input bit wr, input int wpat,
                         input bit noise, input logic [31:0] wd, input bit force_narrow, input bit use_force);
    int bytes = 1 << sz;
    bit nar = use_force ? force_narrow :
              (region == 0) ? !tb_boot : (region == 2 || region == 3);
    int pb = nar ? 1 : 2;
    int beats = (bytes > pb) ? bytes / pb : 1;
    int off = (sz == 2) ? 0 : (sz == 1) ? (region % 2) * 2 : region % 4;
    logic [25:0] base = {3'(region), 23'h000A40 + 23'(off)};
    logic [5:0] exp_ce = (region < 6) ? ~(6'd1 << region) : 6'h3F;
    int n_obs = 0, seen = 0, w_left = 0;
    bit prev = 0, got = 0;
    logic [31:0] rd = 0, exp_rd = 0;
    cur_narrow = nar;
    @(posedge clk_i); #1;
    chk(ready_o, "R10 ready idle", {31'b0, ready_o}, 1);
    req_i = 1; we_i = wr; size_i = 2'(sz); addr_i = base; wdata_i = wd;
    while (!got && n_obs < 200) begin
      @(posedge clk_i); #1;
      req_i = 0;
      if (done_o) begin
        got = 1; rd = rdata_o; ext_wait_i = 0;
      end else begin
        bit strb = !ext_oe_no || !ext_we_no;
        n_obs++;
        chk(ext_ce_no == exp_ce, "R8 chip enable", {26'b0, ext_ce_no}, {26'b0, exp_ce});
        chk(ext_wide_o == (sz != 0), "R6 width flag", {31'b0, ext_wide_o}, {31'b0, sz != 0});
        chk(!ready_o, "R10 busy", {31'b0, ready_o}, 0);
        chk(!(!ext_oe_no && !ext_we_no), "R4 exclusive", {ext_oe_no, ext_we_no}, 2'b11);
        chk(ext_data_oe_o == wr, "R3 drive enable", {31'b0, ext_data_oe_o}, {31'b0, wr});
        if (strb) begin
          chk(wr ? (!ext_we_no && ext_oe_no) : (!ext_oe_no && ext_we_no),
              wr ? "R3 write strobe" : "R2 read strobe", {ext_oe_no, ext_we_no},
              wr ? 2'b10 : 2'b01);
          if (!prev) begin
            logic [25:0] ea = base + 26'(seen * pb);
            chk(ext_addr_o == ea, "R9 beat address", {6'b0, ext_addr_o}, {6'b0, ea});
            if (wr) begin
              logic [15:0] ed;
              if (nar) ed = {8'h00, wd[seen*8 +: 8]};
              else if (sz == 0) ed = {2{wd[7:0]}};
              else ed = wd[seen*16 +: 16];
              chk(ext_data_o == ed, "R11 write lanes", {16'b0, ext_data_o}, {16'b0, ed});
            end
            seen++;
            w_left = wpat;
          end
          ext_wait_i = (w_left > 0);
          if (w_left > 0) w_left--;
        end else begin
          chk(ext_oe_no && ext_we_no, "R4 setup strobes", {ext_oe_no, ext_we_no}, 2'b11);
          ext_wait_i = noise;
        end
        prev = strb;
      end
    end
    chk(got, "R10 done seen", {31'b0, got}, 1);
    chk(seen == beats, "R9 access count", seen, beats);
    chk(n_obs == beats * (2 + wpat), "R5 cycle count", n_obs, beats * (2 + wpat));
    if (!wr) begin
      for (int i = 0; i < bytes; i++) exp_rd[i*8 +: 8] = mb(base + 26'(i));
      chk(rd == exp_rd, "R10 R11 read data", rd, exp_rd);
    end
    @(posedge clk_i); #1;
    chk(!done_o && ext_oe_no && ext_we_no && ext_ce_no == 6'h3F, "R4 R10 after done",
        {done_o, ext_oe_no, ext_we_no, ext_ce_no}, {3'b011, 6'h3F});
  endtask

  initial begin
    #(4 * 150000);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog R10 act=hung exp=done");
      $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    for (int s = 0; s < 2; s++) begin
      do_reset(s[0]);
      for (int r = 0; r < 8; r++)
        for (int z = 0; z < 3; z++)
          for (int w = 0; w < 2; w++)
            run_txn(r, z, w[0], (r + z + w) % 3, r[0], 32'hA1B2C3D4 ^ {24'b0, 8'(r * 16 + z * 4 + w)},
                    0, 0);
      // R7: strap flip after reset must not change region 0 port width
      boot_wide_i = ~s[0];
      run_txn(0, 2, 0, 1, 1, 32'h0, !s[0], 1);
      run_txn(0, 1, 1, 0, 0, 32'h00005A3C, !s[0], 1);
    end
    finished = 1;
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule